// File: doc/BRIEF.md
# Echo-Based Link Delay Calibrator

This block sits on the master end of a point-to-point serial link and measures the one-way transit time to the remote end. When a start command arrives, it drives a calibration pulse toward the link. It reads the local time digitizer's free-running timestamp in the first cycle of that pulse. It then waits for the far end to send the pulse back, and reads the timestamp again in the cycle the echo is seen.

The far end needs a fixed, known number of timestamp units to turn the pulse around. The link is taken to have equal delay in both directions. The block removes the turnaround from the round trip and halves the remainder to give the one-way delay. It reports the integer part, plus a flag for the half unit lost by the halving.

A programmable cycle limit bounds the wait for the echo. If the limit expires, the block raises a one-cycle timeout indication and becomes ready for a new command. The last good delay result is kept while this happens.

Top module: `echo_delay_cal`

## Requirements
- R1: After reset, calPulse, doneOut and timeoutOut are 0, and delayOut and halfLsb are 0.
- R2: A startIn seen high while the block is idle makes calPulse go high in the next cycle. calPulse then stays high for exactly PULSE_CYC consecutive cycles (default 4).
- R3: T0 is the tsIn value in the first cycle calPulse is high. T3 is the tsIn value in the cycle in which echoIn is sampled high during the echo wait. The echo wait begins in the cycle after the pulse ends.
- R4: netDelay = (T3 − T0 − turnaround) mod 2^TS_W. delayOut = netDelay >> 1 and halfLsb = netDelay bit 0. This holds even when the timestamp wraps between T0 and T3.
- R5: doneOut is high for exactly one cycle, two cycles after the echo cycle. delayOut and halfLsb are valid in that cycle and hold their value until the next successful measurement.
- R6: The echo wait lasts at most timeoutCycles cycles (timeoutCycles ≥ 1). If no echo arrives, timeoutOut is high for one cycle, timeoutCycles cycles after the wait began, which is PULSE_CYC + timeoutCycles cycles after calPulse rises. delayOut and halfLsb keep their previous value and doneOut stays low.
- R7: echoIn has no effect while the block is idle or while calPulse is high.
- R8: startIn has no effect while a measurement or timeout report is in progress. No second pulse is sent, and the result refers to the original T0.
- R9: A new measurement can be started in the first idle cycle after doneOut or timeoutOut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Start a calibration |
| echoIn | input | 1 | Echo returned by the far end |
| turnaround | input | TS_W | Far-end turnaround time, timestamp units |
| timeoutCycles | input | TMO_W | Echo wait limit, clock cycles |
| tsIn | input | TS_W | Free-running timestamp from the digitizer |
| calPulse | output | 1 | Calibration pulse toward the link |
| delayOut | output | TS_W-1 | One-way delay, integer units |
| halfLsb | output | 1 | Half-unit remainder of the delay |
| doneOut | output | 1 | One-cycle result-valid strobe |
| timeoutOut | output | 1 | One-cycle echo-timeout strobe |

## Verification
Suppose the controller captures a timestamp one cycle early or late, or mis-counts the pulse or wait window. The error then appears at the ports as a delay result off by half a cycle's worth of units. It can also show up as a pulse of the wrong length or a timeout strobe in the wrong cycle. Each of these is visible within the measurement that caused it.

A wrong modulo or shift shows up at once in the wrap and odd-remainder cases. A state machine that reacts to stray echoes or starts gives itself away through an extra pulse, a premature done, or a changed held result. This is visible in the cycles right after the stray stimulus.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_COMPUTE,
    ST_DONE,
    ST_TIMEOUT
  } calState_t;

  typedef struct packed {
    logic capT0;
    logic capT3;
    logic compute;
  } calStrobe_t;
endpackage

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import cal_pkg::*;
#(
  parameter int PULSE_CYC = 4,
  parameter int TMO_W     = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic             echoIn,
  input  logic [TMO_W-1:0] timeoutCycles,
  output calStrobe_t       strobe,
  output logic             calPulse,
  output logic             doneOut,
  output logic             timeoutOut
);
  localparam int PC_W = $clog2(PULSE_CYC + 1);
  localparam logic [PC_W-1:0] PULSE_LAST = PC_W'(PULSE_CYC - 1);

  calState_t       state, stateNext;
  logic [PC_W-1:0] pulseCnt;
  logic [TMO_W-1:0] waitCnt;
  logic            waitExpired;

  assign waitExpired = (waitCnt == timeoutCycles - TMO_W'(1));

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:    if (startIn) stateNext = ST_SEND;
      ST_SEND:    if (pulseCnt == PULSE_LAST) stateNext = ST_WAIT;
      ST_WAIT: begin
        if (echoIn)           stateNext = ST_COMPUTE;
        else if (waitExpired) stateNext = ST_TIMEOUT;
      end
      ST_COMPUTE: stateNext = ST_DONE;
      ST_DONE:    stateNext = ST_IDLE;
      ST_TIMEOUT: stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pulseCnt <= '0;
      waitCnt  <= '0;
    end else begin
      state    <= stateNext;
      pulseCnt <= (state == ST_SEND) ? pulseCnt + PC_W'(1) : '0;
      waitCnt  <= (state == ST_WAIT) ? waitCnt + TMO_W'(1) : '0;
    end
  end

  always_comb begin
    strobe.capT0   = (state == ST_SEND) && (pulseCnt == '0);
    strobe.capT3   = (state == ST_WAIT) && echoIn;
    strobe.compute = (state == ST_COMPUTE);
  end

  assign calPulse   = (state == ST_SEND);
  assign doneOut    = (state == ST_DONE);
  assign timeoutOut = (state == ST_TIMEOUT);

  // R3: the departure timestamp is taken once per pulse
  a_r3_t0_once: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capT0 |=> !strobe.capT0);

  // R2: the pulse ending hands over to the echo wait
  a_r2_pulse_then_wait: assert property (@(posedge clk) disable iff (!rstN)
    $fell(calPulse) |-> (state == ST_WAIT));

  // R6: a timeout only follows an echo wait
  a_r6_timeout_from_wait: assert property (@(posedge clk) disable iff (!rstN)
    timeoutOut |-> ($past(state) == ST_WAIT) && !$past(echoIn));

  // R5: done follows the compute strobe by one cycle
  a_r5_done_after_compute: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> $past(strobe.compute));
endmodule

// File: rtl/cal_datapath.sv
module cal_datapath
  import cal_pkg::*;
#(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  calStrobe_t      strobe,
  input  logic [TS_W-1:0] tsIn,
  input  logic [TS_W-1:0] turnaround,
  output logic [TS_W-2:0] delayOut,
  output logic            halfLsb
);
  logic [TS_W-1:0] t0Reg, t3Reg;
  logic [TS_W-1:0] roundTrip, netDelay;

  // modulo-2^TS_W arithmetic absorbs a timestamp wrap between T0 and T3
  assign roundTrip = t3Reg - t0Reg;
  assign netDelay  = roundTrip - turnaround;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      t0Reg    <= '0;
      t3Reg    <= '0;
      delayOut <= '0;
      halfLsb  <= 1'b0;
    end else begin
      if (strobe.capT0) t0Reg <= tsIn;
      if (strobe.capT3) t3Reg <= tsIn;
      if (strobe.compute) begin
        delayOut <= netDelay[TS_W-1:1];
        halfLsb  <= netDelay[0];
      end
    end
  end

  // R5: the result is held between compute strobes
  a_r5_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.compute |=> $stable(delayOut) && $stable(halfLsb));

  // R3: arrival is never captured together with departure
  a_r3_capture_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.capT0 && strobe.capT3));
endmodule

// File: rtl/echo_delay_cal.sv
module echo_delay_cal
  import cal_pkg::*;
#(
  parameter int TS_W      = 16,
  parameter int TMO_W     = 16,
  parameter int PULSE_CYC = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic             echoIn,
  input  logic [TS_W-1:0]  turnaround,
  input  logic [TMO_W-1:0] timeoutCycles,
  input  logic [TS_W-1:0]  tsIn,
  output logic             calPulse,
  output logic [TS_W-2:0]  delayOut,
  output logic             halfLsb,
  output logic             doneOut,
  output logic             timeoutOut
);
  calStrobe_t strobe;

  cal_ctrl #(.PULSE_CYC(PULSE_CYC), .TMO_W(TMO_W)) uCtrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .echoIn(echoIn),
    .timeoutCycles(timeoutCycles), .strobe(strobe), .calPulse(calPulse),
    .doneOut(doneOut), .timeoutOut(timeoutOut)
  );

  cal_datapath #(.TS_W(TS_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .tsIn(tsIn),
    .turnaround(turnaround), .delayOut(delayOut), .halfLsb(halfLsb)
  );

  // R1/R6: done and timeout never coincide
  a_r6_status_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(doneOut && timeoutOut));
endmodule

// File: tb/tb_echo_delay_cal.sv
`timescale 1ns/1ps
module tb_echo_delay_cal;
  localparam int TS_W = 16;
  localparam int PULSE = 4;

  logic clk = 0, rstN = 0, startIn = 0, echoIn = 0;
  logic [TS_W-1:0] turnaround = '0;
  logic [15:0] timeoutCycles = 16'd1000;
  logic [TS_W-1:0] tsFree = '0, tsBase = '0, tsIn;
  logic calPulse, halfLsb, doneOut, timeoutOut;
  logic [TS_W-2:0] delayOut;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #2 clk = ~clk;
  always_ff @(posedge clk) tsFree <= tsFree + 1'b1;
  assign tsIn = tsFree + tsBase;

  echo_delay_cal dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .echoIn(echoIn),
    .turnaround(turnaround), .timeoutCycles(timeoutCycles), .tsIn(tsIn),
    .calPulse(calPulse), .delayOut(delayOut), .halfLsb(halfLsb),
    .doneOut(doneOut), .timeoutOut(timeoutOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // issue start, return at the negedge of the first pulse cycle with T0
  task automatic launch(output logic [TS_W-1:0] t0);
    @(negedge clk) startIn = 1;
    @(negedge clk) startIn = 0;
    check(calPulse == 1'b1, "R2 pulse rises", calPulse, 1);
    t0 = tsIn;
  endtask

  // normal measurement: echo D cycles after pulse rise
  task automatic measure(input int d, input logic [TS_W-1:0] turn);
    logic [TS_W-1:0] t0, t3, net;
    int highCnt;
    turnaround = turn;
    launch(t0);
    highCnt = 1;
    for (int i = 1; i < d; i++) begin
      @(negedge clk);
      if (calPulse) highCnt++;
    end
    @(negedge clk);
    echoIn = 1; t3 = tsIn;
    check(highCnt == PULSE, "R2 pulse width", highCnt, PULSE);
    @(negedge clk) echoIn = 0;
    check(doneOut == 1'b0, "R5 done not early", doneOut, 0);
    @(negedge clk);
    net = t3 - t0 - turn;
    check(doneOut == 1'b1, "R5 done two cycles after echo", doneOut, 1);
    check(delayOut == net[TS_W-1:1], "R4 delay", delayOut, net[TS_W-1:1]);
    check(halfLsb == net[0], "R4 half lsb", halfLsb, net[0]);
    @(negedge clk);
    check(doneOut == 1'b0, "R5 done one cycle", doneOut, 0);
    check(delayOut == net[TS_W-1:1], "R5 delay held", delayOut, net[TS_W-1:1]);
  endtask

  task automatic testReset();
    check(calPulse == 0 && doneOut == 0 && timeoutOut == 0, "R1 outputs idle",
          {calPulse, doneOut, timeoutOut}, 0);
    check(delayOut == 0 && halfLsb == 0, "R1 result cleared", delayOut, 0);
  endtask

  task automatic testTimeout(input bit strayEcho);
    logic [TS_W-1:0] t0, oldDelay;
    logic oldHalf;
    int n;
    bit sawDone;
    oldDelay = delayOut; oldHalf = halfLsb;
    timeoutCycles = 16'd20;
    launch(t0);
    n = 0; sawDone = 0;
    while (!timeoutOut && n < 100) begin
      @(negedge clk);
      n++;
      if (strayEcho) echoIn = (n == 1);   // R7 echo only during the pulse
      if (doneOut) sawDone = 1;
    end
    echoIn = 0;
    check(n == PULSE + 20, strayEcho ? "R7 echo in pulse ignored" : "R6 timeout cycle",
          n, PULSE + 20);
    check(!sawDone, "R6 no done on timeout", sawDone, 0);
    check(delayOut == oldDelay && halfLsb == oldHalf, "R6 result kept", delayOut, oldDelay);
    @(negedge clk);
    check(timeoutOut == 1'b0, "R6 timeout one cycle", timeoutOut, 0);
    timeoutCycles = 16'd1000;
  endtask

  task automatic testEchoIdle();
    logic [TS_W-1:0] oldDelay;
    bit seen;
    oldDelay = delayOut; seen = 0;
    @(negedge clk) echoIn = 1;
    @(negedge clk) echoIn = 0;
    repeat (6) begin
      @(negedge clk);
      if (doneOut || calPulse || timeoutOut) seen = 1;
    end
    check(!seen, "R7 echo in idle ignored", seen, 0);
    check(delayOut == oldDelay, "R7 result unchanged", delayOut, oldDelay);
  endtask

  task automatic testStartBusy();
    logic [TS_W-1:0] t0, t3, net;
    bit extra;
    turnaround = 16'd3;
    launch(t0);
    repeat (6) @(negedge clk);
    startIn = 1;
    @(negedge clk) startIn = 0;
    extra = 0;
    repeat (5) begin
      if (calPulse) extra = 1;
      @(negedge clk);
    end
    check(!extra, "R8 no second pulse", extra, 0);
    echoIn = 1; t3 = tsIn;
    @(negedge clk) echoIn = 0;
    @(negedge clk);
    net = t3 - t0 - 16'd3;
    check(doneOut == 1'b1, "R8 done", doneOut, 1);
    check(delayOut == net[TS_W-1:1], "R8 delay from original T0", delayOut, net[TS_W-1:1]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();                       // R1
    measure(10, 16'd6);                // R2 R3 R4 R5 even remainder
    measure(13, 16'd4);                // R4 odd remainder
    tsBase = 16'hFFF8 - tsFree;        // R4 wrap between T0 and T3
    measure(30, 16'd2);
    measure(200, 16'd100);             // R4 long link
    testTimeout(0);                    // R6
    measure(PULSE, 16'd1);             // R9 restart after timeout, first wait cycle
    testTimeout(1);                    // R7
    testEchoIdle();                    // R7
    testStartBusy();                   // R8
    @(negedge clk);
    measure(9, 16'd0);                 // R9 restart after done
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule